// File: doc/BRIEF.md
# Period-Match Timer with PWM Output

This block is an 8-bit up-counter that runs from zero to a programmable period value and then restarts at zero. The counter advances once per instruction cycle, where one instruction cycle is four cycles of `clk`. A selectable input prescaler slows it by 1, 4 or 16. Each restart is a period boundary. A 4-bit postscaler counts the boundaries and emits a one-cycle interrupt pulse after a programmable number of them.

The same time base drives a pulse-width output with 10-bit resolution. The duty value is built from an 8-bit duty byte and two extension bits. It is compared against the timer extended below its LSB by two fractional bits. With prescale 1:1, those two bits are the quarter-cycle phase. Otherwise they are the upper two bits of the live prescaler count. Duty writes go into a buffer, and the buffer is copied to the active comparator value only at a period boundary, so a pulse is never cut short or stretched partway through.

Software reaches the block through a simple write bus: a strobe, a 3-bit address and a data byte. A separate gate input lets the surrounding chip stall counting.

Top module: `period_pwm_timer`

## Requirements
- R1: After reset, `timer_value` is 0, `pwm_out` and `period_irq` are low, the control register is 0 (timer stopped), and the period register is 255, so a timer started without writing the period restarts every 1024 clocks at 1:1.
- R2: Control register (address 2) bits [1:0] select the prescaler: 00 divides by 1, 01 by 4, 1x by 16. The timer advances once every 4×divide clocks.
- R3: The timer advances only while control bit [2] (run) is 1 and `tmr_gate` is 1. Otherwise it holds its value.
- R4: When the timer equals the period register (address 1) and advances, it becomes 0 and a new period begins. One PWM period is (period+1)×4×divide clocks.
- R5: The active duty value D is {duty byte (address 3), mode register bits [5:4]}. In each period `pwm_out` is high for D×divide clocks starting at the boundary. With D = 0 it stays low. With D ≥ 4×(period+1) it stays high for the whole period.
- R6: Control bits [6:3] hold a postscale value S. `period_irq` is a single-cycle pulse issued once per S+1 period boundaries.
- R7: A duty write made partway through a period leaves that period's pulse width unchanged. The new value is used from the next period on.
- R8: `pwm_out` can go high only while mode register bits [3:2] are 11. For any other mode value it is held low.
- R9: A write to address 0 loads the timer with the data byte. That write, and any control-register write, clears the prescaler and postscaler counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-cycle clock; four cycles form one instruction cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_gate | input | 1 | Global count enable from the surrounding chip |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 timer, 1 period, 2 control, 3 duty byte, 4 mode |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Pulse-width output |
| period_irq | output | 1 | One-cycle pulse every S+1 period boundaries |
| timer_value | output | 8 | Current timer count |

## Verification
Three prescale settings are each paired with a different period and duty, so the measured period and high time show whether the divide ratio, the period reload and the fractional duty bits are applied correctly. The duty boundary runs D = 4×(period+1)−1 against D = 4×(period+1) and D = 0, which separates a one-clock low gap from a steady-high or steady-low output. A duty rewrite in mid-period shows whether buffering is deferred to the boundary. Postscaled interrupt spacing, a stopped or gated timer, a loaded timer value and the restart delay after a load show whether the counts are cleared and the enables are honoured.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int TMR_W  = 8;
  localparam int FRAC_W = 2;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;
  localparam int DUTY_W = TMR_W + FRAC_W;

  // control byte: [6:3] postscale, [2] run, [1:0] prescale select
  typedef struct packed {
    logic [POST_W-1:0] post_sel;
    logic              run;
    logic [1:0]        pre_sel;
  } ctrl_t;

  // last prescaler count before the timer advances
  function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
    case (sel)
      2'b00:   return PRE_W'(0);
      2'b01:   return PRE_W'(3);
      default: return PRE_W'(15);
    endcase
  endfunction

  // fractional LSBs that extend the timer to the duty resolution
  function automatic logic [FRAC_W-1:0] frac_pick(input logic [1:0] sel,
                                                  input logic [1:0] phase,
                                                  input logic [PRE_W-1:0] pre);
    case (sel)
      2'b00:   return phase;
      2'b01:   return pre[1:0];
      default: return pre[3:2];
    endcase
  endfunction
endpackage

// File: rtl/ptmr_count.sv
module ptmr_count
  import ptmr_pkg::*;
#(
  parameter int TW = TMR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    pre_sel,
  input  logic          tmr_load,
  input  logic [TW-1:0] load_val,
  input  logic          pre_clr,
  input  logic [TW-1:0] period,
  output logic [TW-1:0] timer,
  output logic [FRAC_W-1:0] frac,
  output logic          period_end
);
  logic [1:0]       phase;
  logic [PRE_W-1:0] pre_cnt;
  logic             tick;
  logic             advance;

  assign tick       = (phase == 2'd3);
  assign advance    = run && tick && (pre_cnt == pre_last(pre_sel));
  assign period_end = advance && (timer == period);
  assign frac       = frac_pick(pre_sel, phase, pre_cnt);

  // quarter-cycle phase runs freely, like the instruction clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_cnt <= '0;
    else if (pre_clr)        pre_cnt <= '0;
    else if (run && tick)    pre_cnt <= (pre_cnt == pre_last(pre_sel)) ? '0 : pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          timer <= '0;
    else if (tmr_load)   timer <= load_val;
    else if (advance)    timer <= (timer == period) ? '0 : timer + 1'b1;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_last(pre_sel)); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_end && !tmr_load |=> timer == '0); // R4
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !tmr_load |=> $stable(timer)); // R3
endmodule

// File: rtl/ptmr_post.sv
module ptmr_post
  import ptmr_pkg::*;
#(
  parameter int PW = POST_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] post_sel,
  input  logic          period_end,
  output logic          irq
);
  logic [PW-1:0] cnt;
  logic          last;

  assign last = (cnt == post_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (period_end)  cnt <= last ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= period_end && last && !clr;
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6
  AST_IRQ_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> !irq); // R6
endmodule

// File: rtl/ptmr_pwm.sv
module ptmr_pwm
  import ptmr_pkg::*;
#(
  parameter int DW = DUTY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_mode,
  input  logic          period_end,
  input  logic [DW-1:0] duty_buf,
  input  logic [DW-1:0] tbase,
  output logic          pwm_out
);
  logic [DW-1:0] duty_act;
  logic          started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act <= '0;
      started  <= 1'b0;
    end else if (period_end) begin
      duty_act <= duty_buf;
      started  <= 1'b1;
    end
  end

  // high from the boundary until the time base reaches the duty value
  assign pwm_out = pwm_mode && started && (tbase < duty_act);

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(duty_act)); // R7
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    duty_act == '0 |-> !pwm_out); // R5
endmodule

// File: rtl/period_pwm_timer.sv
module period_pwm_timer
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_gate,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic             pwm_out,
  output logic             period_irq,
  output logic [TMR_W-1:0] timer_value
);
  localparam logic [2:0] A_TMR  = 3'd0;
  localparam logic [2:0] A_PER  = 3'd1;
  localparam logic [2:0] A_CTL  = 3'd2;
  localparam logic [2:0] A_DUTY = 3'd3;
  localparam logic [2:0] A_MODE = 3'd4;

  logic [TMR_W-1:0]  period_q;
  ctrl_t             ctrl_q;
  logic [TMR_W-1:0]  duty_hi_q;
  logic [5:0]        mode_q;

  logic              wr_tmr, wr_ctl;
  logic              cnt_clr;
  logic              run;
  logic              pwm_mode;
  logic              period_end;
  logic [FRAC_W-1:0] frac;
  logic [DUTY_W-1:0] duty_buf;

  assign wr_tmr   = wr_en && (wr_addr == A_TMR);
  assign wr_ctl   = wr_en && (wr_addr == A_CTL);
  assign cnt_clr  = wr_tmr || wr_ctl;
  assign run      = ctrl_q.run && tmr_gate;
  assign pwm_mode = (mode_q[3:2] == 2'b11);
  assign duty_buf = {duty_hi_q, mode_q[5:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q  <= '1;
      ctrl_q    <= '0;
      duty_hi_q <= '0;
      mode_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PER:   period_q  <= wr_data;
        A_CTL:   ctrl_q    <= ctrl_t'(wr_data[6:0]);
        A_DUTY:  duty_hi_q <= wr_data;
        A_MODE:  mode_q    <= wr_data[5:0];
        default: ;
      endcase
    end
  end

  ptmr_count #(.TW(TMR_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .pre_sel    (ctrl_q.pre_sel),
    .tmr_load   (wr_tmr),
    .load_val   (wr_data),
    .pre_clr    (cnt_clr),
    .period     (period_q),
    .timer      (timer_value),
    .frac       (frac),
    .period_end (period_end)
  );

  ptmr_post #(.PW(POST_W)) u_post (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cnt_clr),
    .post_sel   (ctrl_q.post_sel),
    .period_end (period_end),
    .irq        (period_irq)
  );

  ptmr_pwm #(.DW(DUTY_W)) u_pwm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_mode   (pwm_mode),
    .period_end (period_end),
    .duty_buf   (duty_buf),
    .tbase      ({timer_value, frac}),
    .pwm_out    (pwm_out)
  );

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_q[3] && mode_q[2]) |-> !pwm_out); // R8
  AST_LOAD_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tmr |=> timer_value == $past(wr_data)); // R9
endmodule

// File: tb/period_pwm_timer_test.sv
module period_pwm_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_gate = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, period_irq;
  logic [7:0] timer_value;

  int checks = 0;
  int errors = 0;

  period_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .tmr_gate(tmr_gate), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
    .period_irq(period_irq), .timer_value(timer_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard of expected PWM periods
  typedef struct { int hi; int per; string req; } exp_t;
  exp_t exp_q[$];
  int   per_cnt = 0, hi_cnt = 0, rise_cnt = 0;
  bit   have_rise = 0;
  logic prev_pwm = 1'b0;

  always @(negedge clk) begin
    if (pwm_out && !prev_pwm) begin
      rise_cnt++;
      if (have_rise && exp_q.size() > 0) begin : cmp
        exp_t e;
        e = exp_q.pop_front();
        chk(per_cnt == e.per, {e.req, " period"}, per_cnt, e.per);
        chk(hi_cnt == e.hi, {e.req, " high time"}, hi_cnt, e.hi);
      end
      have_rise = 1;
      per_cnt = 1;
      hi_cnt = 1;
    end else begin
      per_cnt++;
      if (pwm_out) hi_cnt++;
    end
    prev_pwm = pwm_out;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input int pre, input int post, input bit on);
    return 8'((post << 3) | (int'(on) << 2) | pre);
  endfunction

  task automatic cfg(input int pr, input int duty, input int pre, input int post, input int mode);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'(pr));
    wr(3'd3, 8'(duty >> 2));
    wr(3'd4, 8'(((duty & 3) << 4) | mode));
    wr(3'd2, ctl(pre, post, 1'b1));
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 20000 && exp_q.size() > 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, {req, " scoreboard drained"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic expect_pwm(input int hi, input int per, input int n, input string req);
    for (int i = 0; i < n; i++) exp_q.push_back('{hi, per, req});
    have_rise = 0;
    drain(req);
  endtask

  task automatic count_level(input int n, input logic lvl, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out == lvl) hits++;
    end
  endtask

  task automatic irq_gap(output int gap);
    int guard = 0;
    while (!period_irq && guard < 5000) begin @(negedge clk); guard++; end
    gap = 0;
    @(negedge clk);
    chk(!period_irq, "R6 irq one cycle wide", int'(period_irq), 0);
    gap = 1;
    while (!period_irq && gap < 5000) begin @(negedge clk); gap++; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap, hits, r0, t0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    // R1 reset state, stopped timer
    chk(timer_value == 0, "R1 timer after reset", timer_value, 0);
    chk(pwm_out == 0, "R1 pwm after reset", pwm_out, 0);
    chk(period_irq == 0, "R1 irq after reset", period_irq, 0);
    // R1 period resets to 255: 256*4 clocks between interrupts
    wr(3'd2, ctl(0, 0, 1'b1));
    irq_gap(gap);
    chk(gap == 1024, "R1 default period 255", gap, 1024);

    // R2 R4 R5 prescale 1:1
    cfg(9, 20, 0, 0, 4'b1100);
    expect_pwm(20, 40, 3, "R2 R4 R5 div1");
    // R2 prescale 1:4 with fractional bits from prescaler
    cfg(4, 7, 1, 0, 4'b1100);
    expect_pwm(28, 80, 2, "R2 R5 div4");
    // R2 prescale 1:16
    cfg(2, 5, 2, 0, 4'b1101);
    expect_pwm(80, 192, 2, "R2 R5 div16");
    // R5 boundary: one clock below the period
    cfg(3, 15, 0, 0, 4'b1100);
    expect_pwm(15, 16, 3, "R5 duty period-1");
    // R5 duty equal to period stays high
    cfg(3, 16, 0, 0, 4'b1100);
    repeat (40) @(negedge clk);
    count_level(64, 1'b0, hits);
    chk(hits == 0, "R5 duty>=period low samples", hits, 0);
    // R5 zero duty stays low
    cfg(3, 0, 0, 0, 4'b1100);
    repeat (40) @(negedge clk);
    count_level(64, 1'b1, hits);
    chk(hits == 0, "R5 zero duty high samples", hits, 0);

    // R7 mid-period duty write deferred
    cfg(9, 20, 0, 0, 4'b1100);
    exp_q.push_back('{20, 40, "R7 old duty"});
    exp_q.push_back('{30, 40, "R7 new duty"});
    have_rise = 0;
    r0 = rise_cnt;
    for (int i = 0; i < 500 && rise_cnt == r0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    wr(3'd3, 8'd7);
    wr(3'd4, 8'h2C);
    drain("R7");

    // R8 non-PWM modes keep output low
    cfg(9, 20, 0, 0, 4'b1000);
    count_level(120, 1'b1, hits);
    chk(hits == 0, "R8 mode 10xx high samples", hits, 0);
    cfg(9, 20, 0, 0, 4'b0011);
    count_level(120, 1'b1, hits);
    chk(hits == 0, "R8 mode 0011 high samples", hits, 0);

    // R6 postscale 1:3 on 16-clock periods
    cfg(3, 8, 0, 2, 4'b1100);
    irq_gap(gap);
    chk(gap == 48, "R6 postscale 1:3 spacing", gap, 48);
    irq_gap(gap);
    chk(gap == 48, "R6 postscale repeat spacing", gap, 48);

    // R9 timer load while stopped, R3 hold
    wr(3'd1, 8'hFF);
    wr(3'd2, ctl(2, 0, 1'b0));
    wr(3'd0, 8'd5);
    repeat (20) @(negedge clk);
    chk(timer_value == 5, "R9 timer loaded, R3 held while stopped", timer_value, 5);
    tmr_gate = 1'b0;
    wr(3'd2, ctl(2, 0, 1'b1));
    repeat (100) @(negedge clk);
    chk(timer_value == 5, "R3 held while gate low", timer_value, 5);
    // R9 cleared prescaler: first step after 16 instruction cycles
    t0 = timer_value;
    tmr_gate = 1'b1;
    n = 0;
    while (timer_value == t0 && n < 200) begin @(negedge clk); n++; end
    chk(n >= 60 && n <= 65, "R9 R2 restart after clear", n, 62);
    chk(timer_value == 6, "R2 single step", timer_value, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule